// File: doc/BRIEF.md
# Exception Dispatch Controller

This block sits in a processor's control path and decides where execution continues when an event is raised. There are three kinds of event: a synchronous exception, a level-1 interrupt or a debug event. Each cycle it looks at the three event requests and at the status it holds. The status has three fields: an exception-mode flag, a user-mode flag and a 4-bit interrupt level. At most one request is accepted.

An accepted event updates the architectural save registers on one clock edge: saved PC, double-exception PC, debug saved PC and status, cause, fault address and debug cause. On that same edge the block updates the status it holds. One cycle after the request it pulses `taken_o` and presents the vector address.

Vector addresses come from fixed per-kind constants. When relocation is enabled, each constant is rebased from the default base onto the run-time base input. A vector constant of zero counts as unconfigured. The event's register updates are still performed, but the block flags an error and gives no redirect.

The processor writes the status through a write port, for example on a return from an exception.

Top module: `exc_dispatch`

## Requirements
- R1: After reset, all save registers, the status (`ps_o`), `vec_addr_o` and `vec_kind_o` are zero, and `taken_o`/`err_o` are low.
- R2: The vector kind of a general exception or level-1 interrupt is chosen from the status:
  - exception-mode set gives double (kind 3);
  - otherwise user-mode set gives user (kind 2);
  - otherwise kernel (kind 1).
  - The status layout is bit 5 exception-mode, bit 4 user-mode, bits 3:0 interrupt level.
- R3: A non-double event stores the event PC in `epc1_o`. A double event stores it in `depc_o` when `HAS_DEPC` is 1, leaving `epc1_o` unchanged. When `HAS_DEPC` is 0, it stores it in `epc1_o`.
- R4: An accepted synchronous exception writes `cause_i` to `exccause_o` and sets the exception-mode bit.
- R5: `excvaddr_o` takes `vaddr_i` only when an accepted exception has `has_vaddr_i` high; otherwise it keeps its value.
- R6: With `RELOC_EN`=1 the vector is the fixed vector minus `DEFAULT_VECBASE` plus `vecbase_i`. With `RELOC_EN`=0 it is the fixed vector unchanged.
- R7: A debug request is accepted only when the interrupt level is below `DEBUG_LEVEL`. Otherwise it changes no register and gives no pulse.
- R8: An accepted debug event does all of the following:
  - writes `cause_i` to `dbgcause_o`;
  - writes the PC to `epc_dbg_o`;
  - writes the prior status to `eps_dbg_o`;
  - sets the interrupt level to `DEBUG_LEVEL` and sets exception-mode;
  - reports kind 4.
- R9: A level-1 interrupt is accepted only at interrupt level 0. It writes `L1_CAUSE` (default 4) to `exccause_o` and uses the R2 selection.
- R10: If the selected fixed vector is zero, `err_o` pulses for one cycle instead of `taken_o`, `vec_addr_o` keeps its value, and the register updates of the event still occur.
- R11: Outputs change one cycle after the request is sampled. When requests coincide, the exception wins over debug, and debug wins over the interrupt. `taken_o` and `err_o` are never high together.
- R12: A status write through `ps_wr_en_i` takes effect only in a cycle with no accepted event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vecbase_i | input | 32 | Run-time vector base |
| ps_wr_en_i | input | 1 | Status write strobe |
| ps_wr_data_i | input | 6 | Status write value |
| exc_valid_i | input | 1 | Synchronous exception request |
| irq_l1_i | input | 1 | Level-1 interrupt request |
| dbg_valid_i | input | 1 | Debug event request |
| event_pc_i | input | 32 | PC of the event |
| cause_i | input | 6 | Exception or debug cause code |
| has_vaddr_i | input | 1 | Exception carries a fault address |
| vaddr_i | input | 32 | Fault address |
| taken_o | output | 1 | One-cycle redirect pulse |
| err_o | output | 1 | One-cycle unconfigured-vector pulse |
| vec_kind_o | output | 3 | Kind of last event (0 none,1 kernel,2 user,3 double,4 debug) |
| vec_addr_o | output | 32 | Vector address |
| ps_o | output | 6 | Current status |
| epc1_o | output | 32 | Level-1 saved PC |
| depc_o | output | 32 | Double-exception saved PC |
| epc_dbg_o | output | 32 | Debug-level saved PC |
| eps_dbg_o | output | 6 | Debug-level saved status |
| exccause_o | output | 6 | Exception cause |
| excvaddr_o | output | 32 | Fault address register |
| dbgcause_o | output | 6 | Debug cause |

## Verification
The hardest situation to reach is an unconfigured vector on a configuration without a double-exception PC register. In that case the state must still change while the redirect is suppressed. The bench runs a second instance with a zero double vector, no double-PC register and relocation off. That instance is driven by the same stimulus, so each double exception of the main table lands on the error path there. The same comparison checks the un-relocated addresses. Gated debug and interrupt requests need the interrupt level raised first, which the bench does through the status write port.

// File: rtl/exc_dispatch_pkg.sv
package exc_dispatch_pkg;

    localparam int PS_LVL_W = 4;

    typedef enum logic [2:0] {
        VK_NONE   = 3'd0,
        VK_KERNEL = 3'd1,
        VK_USER   = 3'd2,
        VK_DOUBLE = 3'd3,
        VK_DEBUG  = 3'd4
    } vec_kind_e;

    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_EXC  = 2'd1,
        EV_DBG  = 2'd2,
        EV_IRQ  = 2'd3
    } event_e;

    typedef struct packed {
        logic                excm;
        logic                um;
        logic [PS_LVL_W-1:0] ilvl;
    } status_t;

endpackage

// File: rtl/exc_dispatch_classify.sv
module exc_dispatch_classify
    import exc_dispatch_pkg::*;
#(
    parameter int DEBUG_LEVEL = 6
) (
    input  logic      exc_valid_i,
    input  logic      irq_l1_i,
    input  logic      dbg_valid_i,
    input  status_t   ps_i,
    output event_e    ev_o,
    output vec_kind_e kind_o
);
    localparam logic [PS_LVL_W-1:0] DBG_LVL = PS_LVL_W'(DEBUG_LEVEL);

    logic dbg_ok;
    logic irq_ok;

    always_comb begin
        dbg_ok = dbg_valid_i && (ps_i.ilvl < DBG_LVL);
        irq_ok = irq_l1_i && (ps_i.ilvl == '0);

        if (exc_valid_i)  ev_o = EV_EXC;
        else if (dbg_ok)  ev_o = EV_DBG;
        else if (irq_ok)  ev_o = EV_IRQ;
        else              ev_o = EV_NONE;

        case (ev_o)
            EV_DBG:  kind_o = VK_DEBUG;
            EV_NONE: kind_o = VK_NONE;
            default: begin
                if (ps_i.excm)    kind_o = VK_DOUBLE;
                else if (ps_i.um) kind_o = VK_USER;
                else              kind_o = VK_KERNEL;
            end
        endcase
    end
endmodule

// File: rtl/exc_dispatch_vector.sv
module exc_dispatch_vector
    import exc_dispatch_pkg::*;
#(
    parameter int          XLEN            = 32,
    parameter bit          RELOC_EN        = 1'b1,
    parameter logic [31:0] DEFAULT_VECBASE = 32'h4000_0000,
    parameter logic [31:0] KERNEL_VEC      = 32'h4000_0300,
    parameter logic [31:0] USER_VEC        = 32'h4000_0340,
    parameter logic [31:0] DOUBLE_VEC      = 32'h4000_03C0,
    parameter logic [31:0] DEBUG_VEC       = 32'h4000_0280
) (
    input  vec_kind_e         kind_i,
    input  logic [XLEN-1:0]   vecbase_i,
    output logic [XLEN-1:0]   vec_o,
    output logic              unconfigured_o
);
    logic [XLEN-1:0] fixed;

    always_comb begin
        case (kind_i)
            VK_KERNEL: fixed = XLEN'(KERNEL_VEC);
            VK_USER:   fixed = XLEN'(USER_VEC);
            VK_DOUBLE: fixed = XLEN'(DOUBLE_VEC);
            VK_DEBUG:  fixed = XLEN'(DEBUG_VEC);
            default:   fixed = '0;
        endcase
        unconfigured_o = (fixed == '0);
    end

    generate
        if (RELOC_EN) begin : g_reloc
            assign vec_o = fixed - XLEN'(DEFAULT_VECBASE) + vecbase_i;
        end else begin : g_fixed
            logic unused_vecbase;
            assign unused_vecbase = ^vecbase_i;
            assign vec_o = fixed;
        end
    endgenerate
endmodule

// File: rtl/exc_dispatch.sv
module exc_dispatch
    import exc_dispatch_pkg::*;
#(
    parameter int          XLEN            = 32,
    parameter int          CAUSE_W         = 6,
    parameter int          DEBUG_LEVEL     = 6,
    parameter bit          HAS_DEPC        = 1'b1,
    parameter bit          RELOC_EN        = 1'b1,
    parameter int          L1_CAUSE        = 4,
    parameter logic [31:0] DEFAULT_VECBASE = 32'h4000_0000,
    parameter logic [31:0] KERNEL_VEC      = 32'h4000_0300,
    parameter logic [31:0] USER_VEC        = 32'h4000_0340,
    parameter logic [31:0] DOUBLE_VEC      = 32'h4000_03C0,
    parameter logic [31:0] DEBUG_VEC       = 32'h4000_0280
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [XLEN-1:0]    vecbase_i,
    input  logic               ps_wr_en_i,
    input  logic [5:0]         ps_wr_data_i,
    input  logic               exc_valid_i,
    input  logic               irq_l1_i,
    input  logic               dbg_valid_i,
    input  logic [XLEN-1:0]    event_pc_i,
    input  logic [CAUSE_W-1:0] cause_i,
    input  logic               has_vaddr_i,
    input  logic [XLEN-1:0]    vaddr_i,
    output logic               taken_o,
    output logic               err_o,
    output logic [2:0]         vec_kind_o,
    output logic [XLEN-1:0]    vec_addr_o,
    output logic [5:0]         ps_o,
    output logic [XLEN-1:0]    epc1_o,
    output logic [XLEN-1:0]    depc_o,
    output logic [XLEN-1:0]    epc_dbg_o,
    output logic [5:0]         eps_dbg_o,
    output logic [CAUSE_W-1:0] exccause_o,
    output logic [XLEN-1:0]    excvaddr_o,
    output logic [CAUSE_W-1:0] dbgcause_o
);
    localparam logic [PS_LVL_W-1:0] DBG_LVL  = PS_LVL_W'(DEBUG_LEVEL);
    localparam logic [CAUSE_W-1:0]  IRQ_CODE = CAUSE_W'(L1_CAUSE);

    typedef struct packed {
        status_t            ps;
        logic [XLEN-1:0]    epc1;
        logic [XLEN-1:0]    depc;
        logic [XLEN-1:0]    epc_dbg;
        status_t            eps_dbg;
        logic [CAUSE_W-1:0] exccause;
        logic [XLEN-1:0]    excvaddr;
        logic [CAUSE_W-1:0] dbgcause;
        logic [XLEN-1:0]    vec_addr;
        vec_kind_e          kind;
        logic               taken;
        logic               err;
    } state_t;

    state_t    st_d, st_q;
    event_e    ev;
    vec_kind_e kind;
    logic [XLEN-1:0] vec;
    logic            vec_zero;

    exc_dispatch_classify #(
        .DEBUG_LEVEL (DEBUG_LEVEL)
    ) u_classify (
        .exc_valid_i (exc_valid_i),
        .irq_l1_i    (irq_l1_i),
        .dbg_valid_i (dbg_valid_i),
        .ps_i        (st_q.ps),
        .ev_o        (ev),
        .kind_o      (kind)
    );

    exc_dispatch_vector #(
        .XLEN            (XLEN),
        .RELOC_EN        (RELOC_EN),
        .DEFAULT_VECBASE (DEFAULT_VECBASE),
        .KERNEL_VEC      (KERNEL_VEC),
        .USER_VEC        (USER_VEC),
        .DOUBLE_VEC      (DOUBLE_VEC),
        .DEBUG_VEC       (DEBUG_VEC)
    ) u_vector (
        .kind_i         (kind),
        .vecbase_i      (vecbase_i),
        .vec_o          (vec),
        .unconfigured_o (vec_zero)
    );

    always_comb begin
        st_d       = st_q;
        st_d.taken = 1'b0;
        st_d.err   = 1'b0;

        case (ev)
            EV_EXC, EV_IRQ: begin
                st_d.exccause = (ev == EV_EXC) ? cause_i : IRQ_CODE;
                if (ev == EV_EXC && has_vaddr_i) begin
                    st_d.excvaddr = vaddr_i;
                end
                if (kind == VK_DOUBLE && HAS_DEPC) begin
                    st_d.depc = event_pc_i;
                end else begin
                    st_d.epc1 = event_pc_i;
                end
                st_d.ps.excm = 1'b1;
            end
            EV_DBG: begin
                st_d.dbgcause = cause_i;
                st_d.epc_dbg  = event_pc_i;
                st_d.eps_dbg  = st_q.ps;
                st_d.ps.ilvl  = DBG_LVL;
                st_d.ps.excm  = 1'b1;
            end
            default: begin
                if (ps_wr_en_i) begin
                    st_d.ps = status_t'(ps_wr_data_i);
                end
            end
        endcase

        if (ev != EV_NONE) begin
            st_d.kind = kind;
            if (vec_zero) begin
                st_d.err = 1'b1;
            end else begin
                st_d.taken    = 1'b1;
                st_d.vec_addr = vec;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign taken_o    = st_q.taken;
    assign err_o      = st_q.err;
    assign vec_kind_o = st_q.kind;
    assign vec_addr_o = st_q.vec_addr;
    assign ps_o       = st_q.ps;
    assign epc1_o     = st_q.epc1;
    assign depc_o     = st_q.depc;
    assign epc_dbg_o  = st_q.epc_dbg;
    assign eps_dbg_o  = st_q.eps_dbg;
    assign exccause_o = st_q.exccause;
    assign excvaddr_o = st_q.excvaddr;
    assign dbgcause_o = st_q.dbgcause;

    // R11
    taken_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(taken_o && err_o));

    // R2
    double_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid_i && ps_o[5]) |=> (vec_kind_o == 3'd3));

    // R4
    excm_after_exc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid_i |=> (ps_o[5] && exccause_o == $past(cause_i)));

    // R3
    kernel_epc1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid_i && !ps_o[5]) |=> (epc1_o == $past(event_pc_i)));

    // R7
    dbg_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_valid_i && !exc_valid_i && !irq_l1_i && ps_o[3:0] >= DBG_LVL)
        |=> ($stable(dbgcause_o) && !taken_o && !err_o));

    // R11
    taken_sets_excm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        taken_o |-> ps_o[5]);
endmodule

// File: tb/exc_dispatch_tb.sv
module exc_dispatch_tb;
    localparam logic [31:0] VB = 32'h2000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ps_wr_en = 1'b0;
    logic [5:0]  ps_wr_data = '0;
    logic        exc_v = 1'b0, irq_v = 1'b0, dbg_v = 1'b0;
    logic [31:0] pc = '0;
    logic [5:0]  cause = '0;
    logic        has_va = 1'b0;
    logic [31:0] va = '0;

    logic        taken, err, a_taken, a_err;
    logic [2:0]  kind, a_kind;
    logic [31:0] vaddr_o, a_vaddr_o, epc1, a_epc1, depc, a_depc;
    logic [31:0] epcd, a_epcd, excva, a_excva;
    logic [5:0]  ps, a_ps, epsd, a_epsd, ecause, a_ecause, dcause, a_dcause;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    exc_dispatch u_dut (
        .clk(clk), .rst_n(rst_n), .vecbase_i(VB), .ps_wr_en_i(ps_wr_en),
        .ps_wr_data_i(ps_wr_data), .exc_valid_i(exc_v), .irq_l1_i(irq_v),
        .dbg_valid_i(dbg_v), .event_pc_i(pc), .cause_i(cause),
        .has_vaddr_i(has_va), .vaddr_i(va), .taken_o(taken), .err_o(err),
        .vec_kind_o(kind), .vec_addr_o(vaddr_o), .ps_o(ps), .epc1_o(epc1),
        .depc_o(depc), .epc_dbg_o(epcd), .eps_dbg_o(epsd),
        .exccause_o(ecause), .excvaddr_o(excva), .dbgcause_o(dcause));

    exc_dispatch #(.HAS_DEPC(1'b0), .RELOC_EN(1'b0), .DOUBLE_VEC(32'h0)) u_alt (
        .clk(clk), .rst_n(rst_n), .vecbase_i(VB), .ps_wr_en_i(ps_wr_en),
        .ps_wr_data_i(ps_wr_data), .exc_valid_i(exc_v), .irq_l1_i(irq_v),
        .dbg_valid_i(dbg_v), .event_pc_i(pc), .cause_i(cause),
        .has_vaddr_i(has_va), .vaddr_i(va), .taken_o(a_taken), .err_o(a_err),
        .vec_kind_o(a_kind), .vec_addr_o(a_vaddr_o), .ps_o(a_ps), .epc1_o(a_epc1),
        .depc_o(a_depc), .epc_dbg_o(a_epcd), .eps_dbg_o(a_epsd),
        .exccause_o(a_ecause), .excvaddr_o(a_excva), .dbgcause_o(a_dcause));

    typedef struct packed {
        logic [5:0]  ps;
        logic [1:0]  ev;    // 1 exception, 2 debug, 3 level-1 interrupt
        logic [31:0] pc;
        logic [5:0]  cause;
        logic [2:0]  kind;
        logic [31:0] vec;
    } row_t;

    localparam row_t TBL [6] = '{
        '{6'h00, 2'd1, 32'h1000_0010, 6'd5,  3'd1, 32'h2000_0300},
        '{6'h10, 2'd1, 32'h1000_0020, 6'd9,  3'd2, 32'h2000_0340},
        '{6'h20, 2'd1, 32'h1000_0030, 6'd3,  3'd3, 32'h2000_03C0},
        '{6'h30, 2'd1, 32'h1000_0040, 6'd7,  3'd3, 32'h2000_03C0},
        '{6'h10, 2'd3, 32'h1000_0050, 6'd0,  3'd2, 32'h2000_0340},
        '{6'h02, 2'd2, 32'h1000_0060, 6'd11, 3'd4, 32'h2000_0280}
    };

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_ps(logic [5:0] v);
        @(negedge clk);
        ps_wr_en = 1'b1; ps_wr_data = v;
        @(negedge clk);
        ps_wr_en = 1'b0;
    endtask

    // drive requests at a falling edge; results are sampled at the next falling edge
    task automatic fire(logic e, logic d, logic i, logic [31:0] p, logic [5:0] c,
                        logic hv, logic [31:0] a);
        @(negedge clk);
        exc_v = e; dbg_v = d; irq_v = i; pc = p; cause = c; has_va = hv; va = a;
        @(negedge clk);
        exc_v = 1'b0; dbg_v = 1'b0; irq_v = 1'b0; has_va = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] keep;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 taken", {31'b0, taken}, 0);
        chk("R1 ps", {26'b0, ps}, 0);
        chk("R1 epc1", epc1, 0);
        chk("R1 vec", vaddr_o, 0);
        chk("R1 kind", {29'b0, kind}, 0);
        rst_n = 1'b1;

        for (int n = 0; n < 6; n++) begin
            set_ps(TBL[n].ps);
            fire(TBL[n].ev == 2'd1, TBL[n].ev == 2'd2, TBL[n].ev == 2'd3,
                 TBL[n].pc, TBL[n].cause, 1'b0, 32'h0);
            // R2 R9 R8 kind; R6 relocated vector; R11 one-cycle latency
            chk("R2 kind", {29'b0, kind}, {29'b0, TBL[n].kind});
            chk("R11 taken", {31'b0, taken}, 1);
            chk("R6 vec", vaddr_o, TBL[n].vec);
            chk("R4 excm", {31'b0, ps[5]}, 1);
            if (TBL[n].ev == 2'd1) chk("R4 cause", {26'b0, ecause}, {26'b0, TBL[n].cause});
            if (TBL[n].ev == 2'd3) chk("R9 cause", {26'b0, ecause}, 4);
            if (TBL[n].ev == 2'd2) begin
                chk("R8 dbgcause", {26'b0, dcause}, {26'b0, TBL[n].cause});
                chk("R8 epc", epcd, TBL[n].pc);
                chk("R8 eps", {26'b0, epsd}, {26'b0, TBL[n].ps});
                chk("R8 level", {26'b0, ps}, 32'h26);
            end
            if (TBL[n].kind == 3'd3) begin
                chk("R3 depc", depc, TBL[n].pc);
                chk("R10 alt err", {30'b0, a_err, a_taken}, 32'h2);
                chk("R3 alt epc1", a_epc1, TBL[n].pc);
            end else begin
                if (TBL[n].kind != 3'd4) chk("R3 epc1", epc1, TBL[n].pc);
                chk("R6 fixed vec", a_vaddr_o, TBL[n].vec - VB + 32'h4000_0000);
            end
            @(negedge clk);
            chk("R11 pulse ends", {31'b0, taken}, 0);
        end

        // R3 double with depc leaves epc1 alone
        set_ps(6'h20);
        keep = epc1;
        fire(1, 0, 0, 32'h1000_0100, 6'd2, 0, 0);
        chk("R3 epc1 kept", epc1, keep);
        chk("R3 depc", depc, 32'h1000_0100);

        // R10 alt: vec_addr unchanged, state still updated
        set_ps(6'h20);
        keep = a_vaddr_o;
        fire(1, 0, 0, 32'h1000_0110, 6'd13, 0, 0);
        chk("R10 alt vec kept", a_vaddr_o, keep);
        chk("R10 alt cause", {26'b0, a_ecause}, 13);

        // R5 fault address
        set_ps(6'h00);
        fire(1, 0, 0, 32'h1000_0200, 6'd1, 1, 32'hDEAD_0000);
        chk("R5 vaddr", excva, 32'hDEAD_0000);
        set_ps(6'h00);
        fire(1, 0, 0, 32'h1000_0210, 6'd1, 0, 32'hBEEF_0000);
        chk("R5 vaddr kept", excva, 32'hDEAD_0000);

        // R7 debug gated at level 6 and 7
        keep = {26'b0, dcause};
        set_ps(6'h06);
        fire(0, 1, 0, 32'h1000_0300, 6'd33, 0, 0);
        chk("R7 no take lvl6", {31'b0, taken}, 0);
        chk("R7 dbgcause kept", {26'b0, dcause}, keep);
        set_ps(6'h07);
        fire(0, 1, 0, 32'h1000_0310, 6'd34, 0, 0);
        chk("R7 ps kept lvl7", {26'b0, ps}, 32'h07);
        chk("R7 epc_dbg kept", epcd, 32'h1000_0060);

        // R9 interrupt gated at level 1
        set_ps(6'h01);
        keep = epc1;
        fire(0, 0, 1, 32'h1000_0400, 6'd0, 0, 0);
        chk("R9 no take", {31'b0, taken}, 0);
        chk("R9 epc1 kept", epc1, keep);

        // R11 priority: exception over debug, debug over interrupt
        set_ps(6'h00);
        keep = {26'b0, dcause};
        fire(1, 1, 1, 32'h1000_0500, 6'd21, 0, 0);
        chk("R11 exc wins", {29'b0, kind}, 1);
        chk("R11 dbg untouched", {26'b0, dcause}, keep);
        set_ps(6'h00);
        fire(0, 1, 1, 32'h1000_0510, 6'd22, 0, 0);
        chk("R11 dbg wins", {29'b0, kind}, 4);

        // R12 status write ignored in an event cycle
        set_ps(6'h00);
        @(negedge clk);
        ps_wr_en = 1'b1; ps_wr_data = 6'h13; exc_v = 1'b1; pc = 32'h1000_0600;
        @(negedge clk);
        ps_wr_en = 1'b0; exc_v = 1'b0;
        chk("R12 write dropped", {26'b0, ps}, 32'h20);
        set_ps(6'h13);
        chk("R12 write applied", {26'b0, ps}, 32'h13);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule